// File: doc/BRIEF.md
# Windowed Integer Register File

This block holds the integer registers of a core that uses overlapping register windows. A 5-bit architectural register number is mapped to an entry in one physical array. The mapping depends on the current window pointer and, for the global registers, on an alternate-set select input. The file has two combinational read ports and one write port that is clocked.

Next to the storage sit the four window-management fields: the current window pointer, the count of windows that may still be saved, the count of windows that may still be restored, and the count of windows held by another context. A save command moves the pointer up by one, modulo the window count. A restore command moves it down by one. When the relevant counter is already zero, the block leaves all state alone and instead raises a one-cycle overflow (spill) or underflow (fill) flag, for the trap logic to act on. Trap software can overwrite all four fields at once through a synchronous load port.

Top module: `regwin_file`

## Requirements
- R1: Register numbers 0–7 address the globals, and these are shared by every window. 8–15 are outs, 16–23 are locals and 24–31 are ins of the current window.
- R2: Register 0 always reads as zero, in both global sets. A write to register 0 is discarded.
- R3: The outs of window w are the same storage as the ins of window (w+1) mod NWIN, including the wrap from the top window to window 0. Each window has eight locals that no other window can reach.
- R4: A save (op = 2'b01) with the save counter non-zero advances the pointer by one modulo NWIN, decrements the save counter and increments the restore counter.
- R5: A restore (op = 2'b10) with the restore counter non-zero moves the pointer down by one modulo NWIN, increments the save counter and decrements the restore counter.
- R6: A save with the save counter at zero changes no state. It raises `spill` for exactly the one cycle after the command.
- R7: A restore with the restore counter at zero changes no state. It raises `fill` for exactly the one cycle after the command.
- R8: Save and restore keep the sum of the save, restore and other-window counters at NWIN−2.
- R9: After reset the pointer is 0, the save counter is NWIN−2, the restore and other-window counters are 0, and both flags are low.
- R10: With `ld_en` high, all four fields take the load values on the next edge. The load overrides any save or restore issued in the same cycle.
- R11: With `alt_sel` high, registers 1–7 address a separate alternate global set, and the normal globals are left untouched.
- R12: Reads are combinational, and a write appears after the clock edge. A write in the same cycle as a save is placed through the pointer as it stood before the save.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op | input | 2 | Window command: 00 none, 01 save, 10 restore, 11 none |
| alt_sel | input | 1 | Select the alternate global set |
| ld_en | input | 1 | Load all window fields |
| ld_cwp | input | $clog2(NWIN) | Pointer load value |
| ld_cansave | input | $clog2(NWIN) | Save counter load value |
| ld_canrestore | input | $clog2(NWIN) | Restore counter load value |
| ld_otherwin | input | $clog2(NWIN) | Other-window counter load value |
| rd_a_idx | input | 5 | Read port A register number |
| rd_b_idx | input | 5 | Read port B register number |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Write register number |
| wr_data | input | XLEN | Write data |
| rd_a_data | output | XLEN | Read port A data |
| rd_b_data | output | XLEN | Read port B data |
| cwp | output | $clog2(NWIN) | Current window pointer |
| cansave | output | $clog2(NWIN) | Windows that may still be saved |
| canrestore | output | $clog2(NWIN) | Windows that may still be restored |
| otherwin | output | $clog2(NWIN) | Windows held by another context |
| spill | output | 1 | Overflow flag, one cycle |
| fill | output | 1 | Underflow flag, one cycle |

## Verification
The mapping is tested in three ways. A value goes into an out register and is read back as an in after a save, which separates a correct overlap from one that is off by a window. A local is written in two windows, which shows the windows are kept apart. A save from the top window shows the pointer wrapping to 0. Commands are driven until the counters are empty, so the overflow and underflow paths are taken, and the sum of the counters is checked after every command. Another set of patterns toggles the alternate select, loads the fields in the same cycle as a save, and writes in the same cycle as a save. These tell apart the priority of the load and the pointer used for the write.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
   typedef enum logic [1:0] {
      WOP_NONE    = 2'b00,
      WOP_SAVE    = 2'b01,
      WOP_RESTORE = 2'b10,
      WOP_RSVD    = 2'b11
   } win_op_e;

   localparam int unsigned ARCH_W   = 5;
   localparam int unsigned GROUP_SZ = 8;
   localparam int unsigned WIN_BASE = 16; // 8 globals + 8 alternates
endpackage

// File: rtl/regwin_ctrl.sv
module regwin_ctrl
   import regwin_pkg::*;
#(
   parameter int unsigned NWIN = 8,
   localparam int unsigned CW  = $clog2(NWIN)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  win_op_e       cmd,
   input  logic          ld_en,
   input  logic [CW-1:0] ld_cwp,
   input  logic [CW-1:0] ld_cansave,
   input  logic [CW-1:0] ld_canrestore,
   input  logic [CW-1:0] ld_otherwin,
   output logic [CW-1:0] cwp,
   output logic [CW-1:0] cansave,
   output logic [CW-1:0] canrestore,
   output logic [CW-1:0] otherwin,
   output logic          spill,
   output logic          fill
);
   localparam logic [CW-1:0] CS_RESET = CW'(NWIN - 2);

   logic save_ok, rest_ok;
   assign save_ok = (cansave != '0);
   assign rest_ok = (canrestore != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cwp        <= '0;
         cansave    <= CS_RESET;
         canrestore <= '0;
         otherwin   <= '0;
         spill      <= 1'b0;
         fill       <= 1'b0;
      end else begin
         spill <= 1'b0;
         fill  <= 1'b0;
         if (ld_en) begin
            cwp        <= ld_cwp;
            cansave    <= ld_cansave;
            canrestore <= ld_canrestore;
            otherwin   <= ld_otherwin;
         end else begin
            unique case (cmd)
               WOP_SAVE: begin
                  if (save_ok) begin
                     cwp        <= cwp + 1'b1;
                     cansave    <= cansave - 1'b1;
                     canrestore <= canrestore + 1'b1;
                  end else begin
                     spill <= 1'b1;
                  end
               end
               WOP_RESTORE: begin
                  if (rest_ok) begin
                     cwp        <= cwp - 1'b1;
                     cansave    <= cansave + 1'b1;
                     canrestore <= canrestore - 1'b1;
                  end else begin
                     fill <= 1'b1;
                  end
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/regwin_map.sv
module regwin_map
   import regwin_pkg::*;
#(
   parameter int unsigned NWIN   = 8,
   parameter bit          ALT_EN = 1'b1,
   localparam int unsigned CW    = $clog2(NWIN),
   localparam int unsigned PW    = $clog2(WIN_BASE + 2 * GROUP_SZ * NWIN)
) (
   input  logic [ARCH_W-1:0] arch,
   input  logic [CW-1:0]     cwp,
   input  logic              alt,
   output logic [PW-1:0]     phys,
   output logic              is_zero
);
   logic [1:0]    grp;
   logic [2:0]    sub;
   logic          use_alt;
   logic [CW-1:0] prev_w;

   assign grp     = arch[4:3];
   assign sub     = arch[2:0];
   assign prev_w  = cwp - 1'b1;
   assign is_zero = (arch == '0);

   generate
      if (ALT_EN) begin : g_alt
         assign use_alt = alt && (sub != 3'd0);
      end else begin : g_noalt
         logic unused_alt;
         assign unused_alt = alt;
         assign use_alt    = 1'b0;
      end
   endgenerate

   always_comb begin
      unique case (grp)
         2'd0:    phys = PW'({use_alt, sub});
         2'd1:    phys = PW'(WIN_BASE) + PW'({cwp, 1'b1, sub});
         2'd2:    phys = PW'(WIN_BASE) + PW'({cwp, 1'b0, sub});
         default: phys = PW'(WIN_BASE) + PW'({prev_w, 1'b1, sub});
      endcase
   end
endmodule

// File: rtl/regwin_store.sv
module regwin_store #(
   parameter int unsigned DEPTH = 144,
   parameter int unsigned XLEN  = 32,
   parameter int unsigned NRD   = 2,
   localparam int unsigned PW   = $clog2(DEPTH)
) (
   input  logic            clk,
   input  logic            we,
   input  logic [PW-1:0]   waddr,
   input  logic [XLEN-1:0] wdata,
   input  logic [PW-1:0]   raddr [NRD],
   input  logic            rzero [NRD],
   output logic [XLEN-1:0] rdata [NRD]
);
   logic [XLEN-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   generate
      for (genvar p = 0; p < NRD; p++) begin : g_rd
         assign rdata[p] = rzero[p] ? '0 : mem[raddr[p]];
      end
   endgenerate
endmodule

// File: rtl/regwin_file.sv
module regwin_file
   import regwin_pkg::*;
#(
   parameter int unsigned NWIN   = 8,
   parameter int unsigned XLEN   = 32,
   parameter bit          ALT_EN = 1'b1,
   localparam int unsigned CW    = $clog2(NWIN),
   localparam int unsigned DEPTH = WIN_BASE + 2 * GROUP_SZ * NWIN,
   localparam int unsigned PW    = $clog2(DEPTH),
   localparam int unsigned NRD   = 2,
   localparam int unsigned NMAP  = NRD + 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [1:0]      op,
   input  logic            alt_sel,
   input  logic            ld_en,
   input  logic [CW-1:0]   ld_cwp,
   input  logic [CW-1:0]   ld_cansave,
   input  logic [CW-1:0]   ld_canrestore,
   input  logic [CW-1:0]   ld_otherwin,
   input  logic [4:0]      rd_a_idx,
   input  logic [4:0]      rd_b_idx,
   input  logic            wr_en,
   input  logic [4:0]      wr_idx,
   input  logic [XLEN-1:0] wr_data,
   output logic [XLEN-1:0] rd_a_data,
   output logic [XLEN-1:0] rd_b_data,
   output logic [CW-1:0]   cwp,
   output logic [CW-1:0]   cansave,
   output logic [CW-1:0]   canrestore,
   output logic [CW-1:0]   otherwin,
   output logic            spill,
   output logic            fill
);
   generate
      if (NWIN < 2 || NWIN > 32 || (NWIN & (NWIN - 1)) != 0) begin : g_bad_nwin
         $error("regwin_file: NWIN must be a power of two in 2..32");
      end
      if (XLEN < 1) begin : g_bad_xlen
         $error("regwin_file: XLEN must be positive");
      end
   endgenerate

   logic [ARCH_W-1:0] map_arch [NMAP];
   logic [PW-1:0]     map_phys [NMAP];
   logic              map_zero [NMAP];
   logic [PW-1:0]     rd_addr  [NRD];
   logic              rd_zero  [NRD];
   logic [XLEN-1:0]   rd_data  [NRD];

   assign map_arch[0] = rd_a_idx;
   assign map_arch[1] = rd_b_idx;
   assign map_arch[2] = wr_idx;

   regwin_ctrl #(.NWIN(NWIN)) u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .cmd           (win_op_e'(op)),
      .ld_en         (ld_en),
      .ld_cwp        (ld_cwp),
      .ld_cansave    (ld_cansave),
      .ld_canrestore (ld_canrestore),
      .ld_otherwin   (ld_otherwin),
      .cwp           (cwp),
      .cansave       (cansave),
      .canrestore    (canrestore),
      .otherwin      (otherwin),
      .spill         (spill),
      .fill          (fill)
   );

   generate
      for (genvar m = 0; m < NMAP; m++) begin : g_map
         regwin_map #(.NWIN(NWIN), .ALT_EN(ALT_EN)) u_map (
            .arch    (map_arch[m]),
            .cwp     (cwp),
            .alt     (alt_sel),
            .phys    (map_phys[m]),
            .is_zero (map_zero[m])
         );
      end
      for (genvar p = 0; p < NRD; p++) begin : g_rdsel
         assign rd_addr[p] = map_phys[p];
         assign rd_zero[p] = map_zero[p];
      end
   endgenerate

   regwin_store #(.DEPTH(DEPTH), .XLEN(XLEN), .NRD(NRD)) u_store (
      .clk   (clk),
      .we    (wr_en && !map_zero[NRD]),
      .waddr (map_phys[NRD]),
      .wdata (wr_data),
      .raddr (rd_addr),
      .rzero (rd_zero),
      .rdata (rd_data)
   );

   assign rd_a_data = rd_data[0];
   assign rd_b_data = rd_data[1];
endmodule

// File: rtl/regwin_chk.sv
module regwin_chk #(
   parameter int unsigned NWIN = 8,
   parameter int unsigned XLEN = 32,
   localparam int unsigned CW  = $clog2(NWIN)
) (
   input logic            clk,
   input logic            rst_n,
   input logic [1:0]      op,
   input logic            ld_en,
   input logic [CW-1:0]   ld_cwp,
   input logic [CW-1:0]   ld_cansave,
   input logic [CW-1:0]   ld_canrestore,
   input logic [CW-1:0]   ld_otherwin,
   input logic [4:0]      rd_a_idx,
   input logic [4:0]      rd_b_idx,
   input logic [XLEN-1:0] rd_a_data,
   input logic [XLEN-1:0] rd_b_data,
   input logic [CW-1:0]   cwp,
   input logic [CW-1:0]   cansave,
   input logic [CW-1:0]   canrestore,
   input logic [CW-1:0]   otherwin,
   input logic            spill,
   input logic            fill
);
   logic [CW+1:0] cnt_sum;
   assign cnt_sum = (CW+2)'(cansave) + (CW+2)'(canrestore) + (CW+2)'(otherwin);

   assert_save_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (op == 2'b01 && !ld_en && cansave != '0) |=>
         (cwp == CW'($past(cwp) + 1'b1) && cansave == CW'($past(cansave) - 1'b1)
          && canrestore == CW'($past(canrestore) + 1'b1) && !spill));

   assert_restore_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (op == 2'b10 && !ld_en && canrestore != '0) |=>
         (cwp == CW'($past(cwp) - 1'b1) && cansave == CW'($past(cansave) + 1'b1)
          && canrestore == CW'($past(canrestore) - 1'b1) && !fill));

   assert_spill_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (op == 2'b01 && !ld_en && cansave == '0) |=>
         (spill && $stable(cwp) && $stable(cansave) && $stable(canrestore) && $stable(otherwin)));

   assert_fill_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (op == 2'b10 && !ld_en && canrestore == '0) |=>
         (fill && $stable(cwp) && $stable(cansave) && $stable(canrestore) && $stable(otherwin)));

   assert_invariant_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_en && cnt_sum == (CW+2)'(NWIN - 2)) |=> (cnt_sum == (CW+2)'(NWIN - 2)));

   assert_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ld_en |=> (cwp == $past(ld_cwp) && cansave == $past(ld_cansave)
                 && canrestore == $past(ld_canrestore) && otherwin == $past(ld_otherwin)));

   assert_flag_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      spill |-> $past(op) == 2'b01);

   assert_g0_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_a_idx == 5'd0 || rd_b_idx == 5'd0) |->
         ((rd_a_idx != 5'd0 || rd_a_data == '0) && (rd_b_idx != 5'd0 || rd_b_data == '0)));
endmodule

bind regwin_file regwin_chk #(.NWIN(NWIN), .XLEN(XLEN)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .op            (op),
   .ld_en         (ld_en),
   .ld_cwp        (ld_cwp),
   .ld_cansave    (ld_cansave),
   .ld_canrestore (ld_canrestore),
   .ld_otherwin   (ld_otherwin),
   .rd_a_idx      (rd_a_idx),
   .rd_b_idx      (rd_b_idx),
   .rd_a_data     (rd_a_data),
   .rd_b_data     (rd_b_data),
   .cwp           (cwp),
   .cansave       (cansave),
   .canrestore    (canrestore),
   .otherwin      (otherwin),
   .spill         (spill),
   .fill          (fill)
);

// File: tb/regwin_file_test.sv
module regwin_file_test;
   localparam int CLK_PERIOD = 10;
   localparam int NW = 8;
   localparam int CW = $clog2(NW);
   localparam int XL = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    op = 2'b00;
   logic          alt_sel = 1'b0;
   logic          ld_en = 1'b0;
   logic [CW-1:0] ld_cwp = '0, ld_cansave = '0, ld_canrestore = '0, ld_otherwin = '0;
   logic [4:0]    rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
   logic          wr_en = 1'b0;
   logic [XL-1:0] wr_data = '0;
   logic [XL-1:0] rd_a_data, rd_b_data;
   logic [CW-1:0] cwp, cansave, canrestore, otherwin;
   logic          spill, fill;

   regwin_file #(.NWIN(NW), .XLEN(XL)) uut (
      .clk(clk), .rst_n(rst_n), .op(op), .alt_sel(alt_sel), .ld_en(ld_en),
      .ld_cwp(ld_cwp), .ld_cansave(ld_cansave), .ld_canrestore(ld_canrestore),
      .ld_otherwin(ld_otherwin), .rd_a_idx(rd_a_idx), .rd_b_idx(rd_b_idx),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .rd_a_data(rd_a_data), .rd_b_data(rd_b_data), .cwp(cwp), .cansave(cansave),
      .canrestore(canrestore), .otherwin(otherwin), .spill(spill), .fill(fill));

   always #(CLK_PERIOD/2) clk = ~clk;

   typedef struct {
      int          sel;
      logic [31:0] exp;
      string       req;
   } exp_t;

   exp_t q[$];
   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   // bench model of the window fields
   int m_cwp = 0, m_cs = NW - 2, m_cr = 0, m_ow = 0;

   function automatic void expect_v(int sel, logic [31:0] v, string r);
      exp_t e;
      e.sel = sel; e.exp = v; e.req = r;
      q.push_back(e);
   endfunction

   function automatic void expect_state(string r, bit sp, bit fl);
      expect_v(2, 32'(m_cwp), r);
      expect_v(3, 32'(m_cs), r);
      expect_v(4, 32'(m_cr), r);
      expect_v(5, 32'(m_ow), r);
      expect_v(6, 32'(sp), r);
      expect_v(7, 32'(fl), r);
      expect_v(8, 32'(NW - 2), "R8");
   endfunction

   // monitor: compares queued expectations once the cycle's edge has passed
   initial begin
      forever begin
         @(negedge clk);
         while (q.size() > 0) begin
            exp_t e;
            logic [31:0] act;
            e = q.pop_front();
            case (e.sel)
               0: act = rd_a_data;
               1: act = rd_b_data;
               2: act = 32'(cwp);
               3: act = 32'(cansave);
               4: act = 32'(canrestore);
               5: act = 32'(otherwin);
               6: act = 32'(spill);
               7: act = 32'(fill);
               default: act = 32'(cansave) + 32'(canrestore) + 32'(otherwin);
            endcase
            checks++;
            if (act !== e.exp) begin
               failures++;
               $display("FAIL %s sel=%0d actual=%h expected=%h", e.req, e.sel, act, e.exp);
            end
         end
      end
   end

   task automatic step(input logic [1:0] o, input bit a, input bit we,
                       input logic [4:0] wi, input logic [31:0] wd,
                       input logic [4:0] ra, input logic [4:0] rb);
      @(negedge clk);
      #1;
      op = o; alt_sel = a; wr_en = we; wr_idx = wi; wr_data = wd;
      rd_a_idx = ra; rd_b_idx = rb; ld_en = 1'b0;
   endtask

   task automatic load(input int c, input int s, input int r, input int w, input logic [1:0] o);
      @(negedge clk);
      #1;
      op = o; alt_sel = 1'b0; wr_en = 1'b0; ld_en = 1'b1;
      ld_cwp = CW'(c); ld_cansave = CW'(s); ld_canrestore = CW'(r); ld_otherwin = CW'(w);
      m_cwp = c; m_cs = s; m_cr = r; m_ow = w;
      expect_state("R10", 1'b0, 1'b0);
   endtask

   // issue a save (1) or restore (0); model decides success or flag
   task automatic cmd(input bit is_save, input logic [4:0] ra, input logic [4:0] rb,
                      input bit we, input logic [4:0] wi, input logic [31:0] wd);
      bit sp, fl;
      sp = 1'b0; fl = 1'b0;
      step(is_save ? 2'b01 : 2'b10, 1'b0, we, wi, wd, ra, rb);
      if (is_save) begin
         if (m_cs == 0) sp = 1'b1;
         else begin m_cwp = (m_cwp + 1) % NW; m_cs--; m_cr++; end
         expect_state(sp ? "R6" : "R4", sp, 1'b0);
      end else begin
         if (m_cr == 0) fl = 1'b1;
         else begin m_cwp = (m_cwp + NW - 1) % NW; m_cs++; m_cr--; end
         expect_state(fl ? "R7" : "R5", 1'b0, fl);
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R9 reset state
      step(2'b00, 1'b0, 1'b0, 5'd0, 32'h0, 5'd0, 5'd0);
      expect_state("R9", 1'b0, 1'b0);
      expect_v(0, 32'h0, "R9");

      // R2 write to register 0 discarded
      step(2'b00, 1'b0, 1'b1, 5'd0, 32'hDEAD, 5'd0, 5'd0);
      expect_v(0, 32'h0, "R2");
      // R12 write visible after edge; R1 global
      step(2'b00, 1'b0, 1'b1, 5'd3, 32'h33, 5'd3, 5'd0);
      expect_v(0, 32'h33, "R12");
      step(2'b00, 1'b0, 1'b1, 5'd8, 32'h100, 5'd8, 5'd0);
      expect_v(0, 32'h100, "R12");
      step(2'b00, 1'b0, 1'b1, 5'd16, 32'h200, 5'd16, 5'd0);
      expect_v(0, 32'h200, "R12");

      // R3 out -> in across a save; R1 global shared
      cmd(1'b1, 5'd24, 5'd3, 1'b0, 5'd0, 32'h0);
      expect_v(0, 32'h100, "R3");
      expect_v(1, 32'h33, "R1");

      // R3 locals private per window
      step(2'b00, 1'b0, 1'b1, 5'd16, 32'h211, 5'd16, 5'd0);
      expect_v(0, 32'h211, "R3");
      cmd(1'b0, 5'd16, 5'd8, 1'b0, 5'd0, 32'h0);
      expect_v(0, 32'h200, "R3");
      expect_v(1, 32'h100, "R3");

      // R7 underflow at depth zero
      cmd(1'b0, 5'd3, 5'd0, 1'b0, 5'd0, 32'h0);
      step(2'b00, 1'b0, 1'b0, 5'd0, 32'h0, 5'd0, 5'd0);
      expect_state("R7", 1'b0, 1'b0);

      // R4 saves up to the limit, then R6 overflow
      for (int i = 0; i < NW - 2; i++) cmd(1'b1, 5'd3, 5'd0, 1'b0, 5'd0, 32'h0);
      cmd(1'b1, 5'd3, 5'd0, 1'b0, 5'd0, 32'h0);
      step(2'b00, 1'b0, 1'b0, 5'd0, 32'h0, 5'd3, 5'd0);
      expect_state("R6", 1'b0, 1'b0);
      expect_v(0, 32'h33, "R1");

      // R10 load overrides a save in the same cycle
      load(NW - 1, NW - 2, 0, 0, 2'b01);
      // R3 wrap from top window to window 0
      step(2'b00, 1'b0, 1'b1, 5'd10, 32'h77, 5'd10, 5'd0);
      expect_v(0, 32'h77, "R12");
      cmd(1'b1, 5'd26, 5'd0, 1'b0, 5'd0, 32'h0);
      expect_v(0, 32'h77, "R3");
      cmd(1'b0, 5'd10, 5'd0, 1'b0, 5'd0, 32'h0);
      expect_v(0, 32'h77, "R5");

      // R5 restore wrap from window 0
      load(0, 0, 4, 2, 2'b00);
      cmd(1'b0, 5'd0, 5'd0, 1'b0, 5'd0, 32'h0);

      // R11 alternate globals
      step(2'b00, 1'b1, 1'b1, 5'd3, 32'hA3, 5'd3, 5'd0);
      expect_v(0, 32'hA3, "R11");
      step(2'b00, 1'b0, 1'b0, 5'd0, 32'h0, 5'd3, 5'd0);
      expect_v(0, 32'h33, "R11");
      expect_v(1, 32'h0, "R2");
      step(2'b00, 1'b1, 1'b1, 5'd0, 32'hBAD, 5'd0, 5'd3);
      expect_v(0, 32'h0, "R2");
      expect_v(1, 32'hA3, "R11");

      // R12 write in the same cycle as a save uses the old pointer
      cmd(1'b1, 5'd25, 5'd0, 1'b1, 5'd9, 32'h5A5);
      expect_v(0, 32'h5A5, "R12");
      // R6 overflow with other-window count held
      cmd(1'b1, 5'd0, 5'd0, 1'b0, 5'd0, 32'h0);

      step(2'b00, 1'b0, 1'b0, 5'd0, 32'h0, 5'd0, 5'd0);
      @(negedge clk);
      @(negedge clk);
      #1;
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule